// File: doc/BRIEF.md
# Keypad Button Status and Interrupt Unit

This block watches ten debounced button levels (1 = pressed), samples them once per clock and presents them to a register bus as an inverted status word, where a pressed button reads 0 and a released button reads 1. Two pairs of the buttons are physical opposites: right/left and up/down. A mode strap decides whether a pair may be reported with both buttons held. When such reports are forbidden and both buttons of a pair are down, the block reports the whole pair as released. The other buttons pass through unchanged.

The block also holds an interrupt control word. It selects a set of buttons, an enable, and a match mode. In OR mode any selected button pressed is a match. In AND mode every selected button must be pressed. The match condition is evaluated on every clock from the filtered button state, so a new control word takes effect at once. Each rising edge of the condition raises a one-cycle request toward the system interrupt controller.

The bus side is a plain register port. A read request returns its data one cycle later, marked by a one-cycle read-valid strobe. The reader cannot stall the block, so the read data must be taken in that cycle. Writes take effect at the clock edge on which they are presented. Debouncing and interrupt collection are handled outside the block.

Top module: `btn_status_unit`

## Requirements
- R1: After reset the status word reads 0x3FF, the control word reads 0x0000 and `key_irq` is low.
- R2: A read presented on one clock edge returns its data after that edge with `bus_rvalid` high for exactly one cycle. Address 0 is the status word and address 1 is the control word. Status bits 15..10 read 0. A status bit reads 0 for a button pressed at the previous sample, so a button change appears in a read issued one cycle after the change.
- R3: While `allow_opposing` is 0 and buttons 4 (right) and 5 (left) are both pressed, status bits 4 and 5 both read 1.
- R4: While `allow_opposing` is 0 and buttons 6 (up) and 7 (down) are both pressed, status bits 6 and 7 both read 1.
- R5: While `allow_opposing` is 1, no pair is suppressed.
- R6: Buttons 0 to 3, 8 and 9 are never filtered. A pressed pair does not disturb any other bit.
- R7: A write to address 1 stores the written data ANDed with 0xC3FF. Bits 9..0 select buttons, bit 14 enables the interrupt and bit 15 selects AND mode (1) or OR mode (0). A read issued on the same edge as a write returns the old value.
- R8: A write to address 0 changes neither the status word nor the control word.
- R9: In OR mode the condition holds when the enable bit is set and at least one selected button is pressed after filtering.
- R10: In AND mode the condition holds when the enable bit is set, at least one button is selected, and every selected button is pressed after filtering. An empty selection never matches.
- R11: `key_irq` is high for exactly one cycle on each rising edge of the condition. The pulse comes two edges after a button change and one edge after a control write. Rewriting a control word that keeps the condition true raises no new pulse.
- R12: With enable bit 14 clear, `key_irq` stays low whatever the buttons do.
- R13: A pair suppressed under R3 or R4 counts as released in the interrupt condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_pressed | input | 10 | Debounced button levels, 1 = pressed |
| allow_opposing | input | 1 | Strap: 1 allows both buttons of a direction pair to be reported |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 1 | 0 = status word, 1 = interrupt control word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | One-cycle strobe marking read data |
| key_irq | output | 1 | One-cycle interrupt request on a rising condition |

## Verification
The bench presses both buttons of each pair with the strap in either state. A design that filtered the wrong bits, or cleared only one button of a pair, would return a status word with a stray 0. It drives AND mode with a partial selection and with an empty selection, where a design that reduced AND over zero selected buttons would fire with no button held. It rewrites the control word while the condition is already met, where a level output or a missing edge detector would produce a long or repeated request. It also suppresses a held pair selected for the interrupt, where a design that evaluated the raw levels would raise a request that software could never explain from the status word.

// File: rtl/btn_pkg.sv
package btn_pkg;

  // Register selection on the one-bit bus address
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_CTRL   = 1'b1
  } btn_reg_sel_e;

  // Control word field positions (fixed: software decodes them)
  localparam int CTRL_EN_BIT  = 14;
  localparam int CTRL_AND_BIT = 15;

  // Decoded view of the control word
  typedef struct packed {
    logic enable;
    logic and_mode;
  } btn_irq_mode_t;

endpackage

// File: rtl/btn_dir_filter.sv
module btn_dir_filter #(
  parameter int N_KEYS    = 10,
  parameter int N_PAIRS   = 2,
  parameter int PAIR_BASE = 4
) (
  input  logic [N_KEYS-1:0] keys,
  input  logic              allow_opposing,
  output logic [N_KEYS-1:0] keys_filt
);

  localparam int PAIR_TOP = PAIR_BASE + 2 * N_PAIRS;

  logic [N_PAIRS-1:0] pair_kill;

  // One kill flag per opposing pair
  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    localparam int LO = PAIR_BASE + 2 * p;
    assign pair_kill[p] = ~allow_opposing & keys[LO] & keys[LO+1];
  end

  // Pair bits are masked by their kill flag, the rest pass straight through
  for (genvar i = 0; i < N_KEYS; i++) begin : g_bit
    if (i >= PAIR_BASE && i < PAIR_TOP) begin : g_paired
      assign keys_filt[i] = keys[i] & ~pair_kill[(i - PAIR_BASE) / 2];
    end else begin : g_plain
      assign keys_filt[i] = keys[i];
    end
  end

endmodule

// File: rtl/btn_regs.sv
module btn_regs
  import btn_pkg::*;
#(
  parameter int N_KEYS = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [N_KEYS-1:0] status,
  output logic [DATA_W-1:0] ctrl,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);

  function automatic logic [DATA_W-1:0] ctrl_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < N_KEYS; i++) m[i] = 1'b1;
    m[CTRL_EN_BIT]  = 1'b1;
    m[CTRL_AND_BIT] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = ctrl_mask_f();

  btn_reg_sel_e sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel = btn_reg_sel_e'(bus_addr);

  always_comb begin
    rd_mux = '0;
    if (sel == SEL_CTRL) rd_mux = ctrl;
    else                 rd_mux[N_KEYS-1:0] = status;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl       <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      // Status writes have no target: only the control word is writable
      if (bus_wr && sel == SEL_CTRL) ctrl <= bus_wdata & CTRL_MASK;
    end
  end

  a_r7_ctrl_masked_store: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr) |=> (ctrl == ($past(bus_wdata) & CTRL_MASK)));

  a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr) |=> $stable(ctrl));

  a_r2_rvalid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r2_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

endmodule

// File: rtl/btn_irq_eval.sv
module btn_irq_eval
  import btn_pkg::*;
#(
  parameter int N_KEYS = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_KEYS-1:0] keys_filt,
  input  logic [DATA_W-1:0] ctrl,
  output logic              irq
);

  btn_irq_mode_t     mode;
  logic [N_KEYS-1:0] sel;
  logic [N_KEYS-1:0] hit;
  logic              any_hit;
  logic              all_hit;
  logic              cond;
  logic              cond_q;

  assign mode.enable   = ctrl[CTRL_EN_BIT];
  assign mode.and_mode = ctrl[CTRL_AND_BIT];
  assign sel           = ctrl[N_KEYS-1:0];
  assign hit           = keys_filt & sel;
  assign any_hit       = |hit;
  assign all_hit       = any_hit && (hit == sel);

  always_comb begin
    cond = 1'b0;
    if (mode.enable) cond = mode.and_mode ? all_hit : any_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cond_q <= cond;
      irq    <= cond & ~cond_q;
    end
  end

  a_r11_single_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r12_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[CTRL_EN_BIT] |=> !irq);

  a_r10_empty_and_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[CTRL_AND_BIT] && sel == '0) |=> !irq);

endmodule

// File: rtl/btn_status_unit.sv
module btn_status_unit
  import btn_pkg::*;
#(
  parameter int N_KEYS    = 10,
  parameter int DATA_W    = 16,
  parameter int N_PAIRS   = 2,
  parameter int PAIR_BASE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_KEYS-1:0] key_pressed,
  input  logic              allow_opposing,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              key_irq
);

  logic [N_KEYS-1:0] keys_q;
  logic [N_KEYS-1:0] keys_filt;
  logic [N_KEYS-1:0] status;
  logic [DATA_W-1:0] ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) keys_q <= '0;
    else        keys_q <= key_pressed;
  end

  btn_dir_filter #(
    .N_KEYS   (N_KEYS),
    .N_PAIRS  (N_PAIRS),
    .PAIR_BASE(PAIR_BASE)
  ) u_filter (
    .keys          (keys_q),
    .allow_opposing(allow_opposing),
    .keys_filt     (keys_filt)
  );

  // Active-low presentation
  assign status = ~keys_filt;

  btn_regs #(
    .N_KEYS(N_KEYS),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .status    (status),
    .ctrl      (ctrl),
    .bus_rdata (bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  btn_irq_eval #(
    .N_KEYS(N_KEYS),
    .DATA_W(DATA_W)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .keys_filt(keys_filt),
    .ctrl     (ctrl),
    .irq      (key_irq)
  );

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair_chk
    localparam int LO = PAIR_BASE + 2 * p;
    // R3 / R4: a forbidden pair never shows both buttons as pressed
    a_r3_pair_not_both_low: assert property (@(posedge clk) disable iff (!rst_n)
      !allow_opposing |-> (status[LO] | status[LO+1]));
  end

  a_r5_allow_is_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    allow_opposing |-> (status == ~keys_q));

endmodule

// File: tb/btn_status_unit_tb_top.sv
module btn_status_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  key_pressed = '0;
  logic        allow_opposing = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic        key_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  btn_status_unit dut_i (
    .clk(clk), .rst_n(rst_n), .key_pressed(key_pressed),
    .allow_opposing(allow_opposing), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .key_irq(key_irq)
  );

  // Behavioural reference model, advanced once per rising edge
  logic [9:0]  m_keys;
  logic [15:0] m_ctrl, m_rdata;
  logic        m_prev, m_irq, m_rvalid;

  function automatic logic [9:0] m_filt(logic [9:0] k, logic allow);
    logic [9:0] f = k;
    if (!allow && k[4] && k[5]) begin f[4] = 0; f[5] = 0; end
    if (!allow && k[6] && k[7]) begin f[6] = 0; f[7] = 0; end
    return f;
  endfunction

  function automatic logic m_cond(logic [9:0] f, logic [15:0] c);
    logic [9:0] s = c[9:0];
    if (!c[14]) return 1'b0;
    if (c[15]) return (s != 0) && ((f & s) == s);
    return (f & s) != 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_keys = '0; m_ctrl = '0; m_rdata = '0;
      m_prev = 0; m_irq = 0; m_rvalid = 0;
    end else begin
      logic [9:0] f;
      logic c;
      f = m_filt(m_keys, allow_opposing);
      c = m_cond(f, m_ctrl);
      m_irq = c && !m_prev;
      m_prev = c;
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = bus_addr ? m_ctrl : {6'd0, ~f};
      if (bus_wr && bus_addr) m_ctrl = bus_wdata & 16'hC3FF;
      m_keys = key_pressed;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Every-cycle comparison against the model (R11 and R2)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(key_irq == m_irq, "R11 model irq", key_irq, m_irq);
      check(bus_rvalid == m_rvalid, "R2 model rvalid", bus_rvalid, m_rvalid);
      if (bus_rvalid && m_rvalid)
        check(bus_rdata == m_rdata, "R2 model rdata", bus_rdata, m_rdata);
    end
  end

  // All tasks start and end just after a falling edge
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_write(input bit a, input logic [15:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic read_expect(input bit a, input logic [15:0] exp, input string tag);
    bus_rd = 1; bus_addr = a;
    tick();
    bus_rd = 0;
    check(bus_rvalid === 1'b1 && bus_rdata === exp, tag, bus_rdata, exp);
  endtask

  task automatic set_keys(input logic [9:0] k);
    key_pressed = k;
    tick();
  endtask

  // Expect no request over n cycles
  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin tick(); if (key_irq) seen = 1; end
    check(!seen, tag, seen, 0);
  endtask

  // Expect a pulse exactly d edges from now, then low again
  task automatic pulse_in(input int d, input string tag);
    bit early = 0;
    for (int i = 1; i < d; i++) begin tick(); if (key_irq) early = 1; end
    tick();
    check(!early && key_irq, tag, key_irq, 1);
    tick();
    check(!key_irq, {tag, " width"}, key_irq, 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(key_irq == 0, "R1 irq low after reset", key_irq, 0);
    read_expect(1'b0, 16'h03FF, "R1 status reset");
    read_expect(1'b1, 16'h0000, "R1 control reset");

    // R2 / R6: plain buttons
    set_keys(10'h201);
    read_expect(1'b0, 16'h01FE, "R2 status inverts buttons 0 and 9");
    set_keys(10'h30F);
    read_expect(1'b0, 16'h00F0, "R6 unfiltered bits");

    // R3 / R4 / R6 with pairs forbidden
    set_keys(10'h030);
    read_expect(1'b0, 16'h03FF, "R3 right+left suppressed");
    set_keys(10'h031);
    read_expect(1'b0, 16'h03FE, "R6 bit0 beside suppressed pair");
    set_keys(10'h0C0);
    read_expect(1'b0, 16'h03FF, "R4 up+down suppressed");
    set_keys(10'h050);
    read_expect(1'b0, 16'h03AF, "R6 non-opposing directions pass");
    set_keys(10'h3FF);
    read_expect(1'b0, 16'h00F0, "R3 R4 both pairs suppressed");

    // R5 allowed
    allow_opposing = 1;
    set_keys(10'h0F0);
    read_expect(1'b0, 16'h030F, "R5 pairs reported when allowed");
    allow_opposing = 0;
    set_keys(10'h000);

    // R7 / R8
    do_write(1'b1, 16'hFFFF);
    read_expect(1'b1, 16'hC3FF, "R7 control masked");
    do_write(1'b1, 16'h0000);
    set_keys(10'h002);
    do_write(1'b0, 16'h0000);
    read_expect(1'b0, 16'h03FD, "R8 status unchanged by write");
    read_expect(1'b1, 16'h0000, "R8 control unchanged by status write");
    set_keys(10'h000);

    // R9 OR mode
    do_write(1'b1, 16'h4003);
    key_pressed = 10'h002;
    pulse_in(2, "R9 OR pulse");
    quiet(4, "R11 no repeat while held");
    set_keys(10'h000);

    // R10 AND mode
    do_write(1'b1, 16'hC003);
    set_keys(10'h001);
    quiet(4, "R10 partial selection no match");
    key_pressed = 10'h003;
    pulse_in(2, "R10 AND full match pulse");
    set_keys(10'h000);
    do_write(1'b1, 16'hC000);
    set_keys(10'h3FF);
    quiet(4, "R10 empty selection never matches");
    set_keys(10'h000);

    // R12 disabled
    do_write(1'b1, 16'h0003);
    set_keys(10'h003);
    quiet(4, "R12 disabled no irq");
    set_keys(10'h000);

    // R13 suppressed pair does not trigger
    do_write(1'b1, 16'h4030);
    set_keys(10'h030);
    quiet(4, "R13 suppressed pair no irq");
    allow_opposing = 1;
    pulse_in(1, "R13 pair counts once allowed");
    allow_opposing = 0;
    set_keys(10'h000);

    // R11 control write re-evaluates immediately
    set_keys(10'h001);
    do_write(1'b1, 16'h4001);
    pulse_in(1, "R11 pulse after control write");
    do_write(1'b1, 16'h4001);
    quiet(3, "R11 rewrite while met no pulse");
    read_expect(1'b1, 16'h4001, "R7 control readback");

    tick();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule